// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block produces the lane-enable mask for the first 8-byte block of a SIMD memory span. A start address and an end address arrive together with an element size (bytes, 16-bit halves or 32-bit words) and a lane-order select. The block works out which lanes of the start block lie at or after the start offset. When both addresses sit in the same 8-byte block, it also keeps only the lanes at or before the end offset. The result is an 8-, 4- or 2-bit mask, zero-extended to 64 bits, that a partial store can use directly.

The same request can also ask for the condition flags of the subtraction start minus end. Four flags are produced for the 32-bit view and four for the 64-bit view of that difference. The flags always come from the full address values. A 32-bit addressing mode clears the upper address half before the block comparison and the offset lookup. A request is accepted in any cycle in which `reqValid` is high, and its result appears one clock later.

Top module: `edge_mask_unit`

## Requirements
- R1: After reset, `resValid`, `flagsValid`, `mask`, `flags32` and `flags64` are all zero. `resValid` is high in exactly the cycle after a cycle with `reqValid` high, and is low in every other cycle.
- R2: With `elemSize`=0 and `littleEnd`=0, lane j (j = 0..7 in address order) maps to mask bit 7-j. The left mask enables lanes j >= addrA[2:0], and the right mask enables lanes j <= addrB[2:0].
- R3: With `elemSize`=0 and `littleEnd`=1, the lanes and offsets are the same as in R2, but lane j maps to mask bit j.
- R4: With `elemSize`=1 there are 4 lanes indexed by address bits [2:1]. With `littleEnd`=0 the left masks are F,7,3,1 and the right masks are 8,C,E,F. With `littleEnd`=1 the left masks are F,E,C,8 and the right masks are 1,3,7,F.
- R5: With `elemSize`=2 there are 2 lanes indexed by address bit 2. With `littleEnd`=0 the left masks are 3,1 and the right masks are 2,3. With `littleEnd`=1 the left masks are 3,2 and the right masks are 1,3. `elemSize`=3 behaves as `elemSize`=0.
- R6: When addrA and addrB agree in every bit above bit 2, the mask is left AND right. Otherwise the mask is the left mask alone.
- R7: When `narrowAddr`=1, both addresses have bits 63:32 cleared before the block comparison and the offset lookup.
- R8: When `setFlags`=1, `flags32` and `flags64` each load {N,Z,V,C} (N in bit 3, C in bit 0) of addrA minus addrB over 32 or 64 bits, using the untruncated inputs. C is the borrow: it is 1 when addrA < addrB unsigned.
- R9: `flagsValid` is high only in a result cycle whose request had `setFlags`=1. A request with `setFlags`=0 leaves `flags32` and `flags64` unchanged.
- R10: Bits 63:8 of `mask` are always zero, and unused lanes of the smaller sizes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe; the inputs below are sampled with it |
| addrA | input | 64 | Span start address |
| addrB | input | 64 | Span end address |
| elemSize | input | 2 | 0 bytes, 1 halves, 2 words, 3 bytes |
| littleEnd | input | 1 | 1 selects low-bit-first lane order |
| narrowAddr | input | 1 | 1 selects 32-bit addressing for the mask |
| setFlags | input | 1 | 1 updates the condition flags |
| resValid | output | 1 | Result valid, one cycle after the request |
| mask | output | 64 | Lane mask, zero-extended |
| flagsValid | output | 1 | Flags updated by this result |
| flags32 | output | 4 | {N,Z,V,C} of the 32-bit difference |
| flags64 | output | 4 | {N,Z,V,C} of the 64-bit difference |

## Verification
In a single result cycle the mask update and the flag update can happen together, or the mask can change while the flags must hold. The bench provokes both by issuing back-to-back requests that alternate `setFlags`, with different addresses on each. Each result is compared against a scoreboard entry. That entry carries the expected mask and the last flag values loaded, so a flag that moves on a no-flag request shows up as a mismatch. Narrow-mode requests with flags on check that truncation reaches the mask but never the flags.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_ALT  = 2'd3
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadFlags;
  } emCtrl_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } ccFlags_t;
endpackage

// File: rtl/edge_mask_ctrl.sv
module edge_mask_ctrl
  import edge_mask_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    setFlags,
  output emCtrl_t strobes,
  output logic    resValid,
  output logic    flagsValid
);
  always_comb begin
    strobes.capture   = reqValid;
    strobes.loadFlags = reqValid && setFlags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid   <= 1'b0;
      flagsValid <= 1'b0;
    end else begin
      resValid   <= reqValid;
      flagsValid <= reqValid && setFlags;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> resValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !resValid); // R1
  AST_FLAGS_NEED_CC: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && setFlags) |=> !flagsValid); // R9
endmodule

// File: rtl/edge_mask_dp.sv
module edge_mask_dp
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int OUT_W     = 64,
  parameter int BLK_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  emCtrl_t           strobes,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [1:0]        elemSize,
  input  logic              littleEnd,
  input  logic              narrowAddr,
  output logic [OUT_W-1:0]  mask,
  output logic [3:0]        flags32,
  output logic [3:0]        flags64
);
  localparam int OFF_W   = $clog2(BLK_BYTES);
  localparam int N_SIZES = 3;

  logic [ADDR_W-1:0]    effA, effB;
  logic [OFF_W-1:0]     offA, offB;
  logic                 sameBlk;
  logic [BLK_BYTES-1:0] candL [N_SIZES];
  logic [BLK_BYTES-1:0] candR [N_SIZES];
  logic [BLK_BYTES-1:0] selL, selR, maskNext, maskReg;
  ccFlags_t             ccNext [2];
  ccFlags_t             cc32Reg, cc64Reg;

  assign effA    = narrowAddr ? {{(ADDR_W-NARROW_W){1'b0}}, addrA[NARROW_W-1:0]} : addrA;
  assign effB    = narrowAddr ? {{(ADDR_W-NARROW_W){1'b0}}, addrB[NARROW_W-1:0]} : addrB;
  assign offA    = effA[OFF_W-1:0];
  assign offB    = effB[OFF_W-1:0];
  assign sameBlk = (effA[ADDR_W-1:OFF_W] == effB[ADDR_W-1:OFF_W]);

  // one mask pair per element size
  for (genvar g = 0; g < N_SIZES; g++) begin : gSize
    localparam int LANES = BLK_BYTES >> g;
    localparam logic [BLK_BYTES-1:0] FULL = BLK_BYTES'((1 << LANES) - 1);
    logic [OFF_W-1:0]     idxA, idxB;
    logic [BLK_BYTES-1:0] leftBe, rightBe, leftLe, rightLe;
    logic [2*BLK_BYTES-1:0] wideR;
    assign idxA    = offA >> g;
    assign idxB    = offB >> g;
    assign leftBe  = FULL >> idxA;
    assign rightBe = FULL & BLK_BYTES'(FULL << (OFF_W'(LANES - 1) - idxB));
    assign leftLe  = FULL & BLK_BYTES'(FULL << idxA);
    assign wideR   = (2*BLK_BYTES)'(2) << idxB;
    assign rightLe = BLK_BYTES'(wideR - (2*BLK_BYTES)'(1));
    assign candL[g] = littleEnd ? leftLe : leftBe;
    assign candR[g] = littleEnd ? rightLe : rightBe;
  end

  always_comb begin
    case (elemSize_e'(elemSize))
      SZ_HALF: begin selL = candL[1]; selR = candR[1]; end
      SZ_WORD: begin selL = candL[2]; selR = candR[2]; end
      default: begin selL = candL[0]; selR = candR[0]; end
    endcase
    maskNext = sameBlk ? (selL & selR) : selL;
  end

  // subtract flags at both widths, on the raw addresses
  for (genvar k = 0; k < 2; k++) begin : gCc
    localparam int FW = (k == 0) ? NARROW_W : ADDR_W;
    logic [FW:0] diff;
    assign diff = {1'b0, addrA[FW-1:0]} - {1'b0, addrB[FW-1:0]};
    assign ccNext[k] = '{neg:   diff[FW-1],
                         zero:  (diff[FW-1:0] == '0),
                         ovf:   (addrA[FW-1] ^ addrB[FW-1]) & (diff[FW-1] ^ addrA[FW-1]),
                         carry: diff[FW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0;
      cc32Reg <= '0;
      cc64Reg <= '0;
    end else begin
      if (strobes.capture)   maskReg <= maskNext;
      if (strobes.loadFlags) begin
        cc32Reg <= ccNext[0];
        cc64Reg <= ccNext[1];
      end
    end
  end

  assign mask    = {{(OUT_W-BLK_BYTES){1'b0}}, maskReg};
  assign flags32 = cc32Reg;
  assign flags64 = cc64Reg;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadFlags |=> ($stable(flags32) && $stable(flags64))); // R9
  AST_WORD_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && elemSize == 2'd2) |=> (mask[OUT_W-1:2] == '0)); // R5
  AST_SAME_ADDR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && addrA == addrB) |=> ($countones(mask) == 1)); // R6
  AST_EQUAL_SETS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadFlags && addrA == addrB) |=> (flags64[2] && flags32[2] && !flags64[0])); // R8
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int OUT_W     = 64,
  parameter int BLK_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [1:0]        elemSize,
  input  logic              littleEnd,
  input  logic              narrowAddr,
  input  logic              setFlags,
  output logic              resValid,
  output logic [OUT_W-1:0]  mask,
  output logic              flagsValid,
  output logic [3:0]        flags32,
  output logic [3:0]        flags64
);
  emCtrl_t strobes;

  edge_mask_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .setFlags   (setFlags),
    .strobes    (strobes),
    .resValid   (resValid),
    .flagsValid (flagsValid)
  );

  edge_mask_dp #(
    .ADDR_W    (ADDR_W),
    .NARROW_W  (NARROW_W),
    .OUT_W     (OUT_W),
    .BLK_BYTES (BLK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .addrA      (addrA),
    .addrB      (addrB),
    .elemSize   (elemSize),
    .littleEnd  (littleEnd),
    .narrowAddr (narrowAddr),
    .mask       (mask),
    .flags32    (flags32),
    .flags64    (flags64)
  );

  AST_FLAGS_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    flagsValid |-> resValid); // R9
endmodule

// File: tb/sim_edge_mask_unit.sv
`timescale 1ns/100ps
module sim_edge_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] addrA = '0, addrB = '0;
  logic [1:0]  elemSize = '0;
  logic        littleEnd = 1'b0, narrowAddr = 1'b0, setFlags = 1'b0;
  logic        resValid, flagsValid;
  logic [63:0] mask;
  logic [3:0]  flags32, flags64;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] expMask;
    logic        expFv;
    logic [3:0]  expF32;
    logic [3:0]  expF64;
    string       tag;
  } item_t;
  item_t sb[$];
  logic [3:0] curF32 = '0, curF64 = '0;

  always #2.5 clk = ~clk;

  edge_mask_unit u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .addrA(addrA), .addrB(addrB),
    .elemSize(elemSize), .littleEnd(littleEnd), .narrowAddr(narrowAddr),
    .setFlags(setFlags), .resValid(resValid), .mask(mask), .flagsValid(flagsValid),
    .flags32(flags32), .flags64(flags64)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane model: lane j in address order, placed by lane order
  function automatic logic [63:0] refMask(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                                          logic le, logic nw);
    logic [63:0] ea, eb, m;
    int lanes, sh, la, lb;
    bit same;
    ea = nw ? {32'h0, a[31:0]} : a;
    eb = nw ? {32'h0, b[31:0]} : b;
    case (sz)
      2'd1:    begin lanes = 4; sh = 1; end
      2'd2:    begin lanes = 2; sh = 2; end
      default: begin lanes = 8; sh = 0; end
    endcase
    la = int'(ea[2:0]) >> sh;
    lb = int'(eb[2:0]) >> sh;
    same = (ea[63:3] == eb[63:3]);
    m = '0;
    for (int j = 0; j < lanes; j++)
      if (j >= la && (!same || j <= lb))
        m[le ? j : lanes - 1 - j] = 1'b1;
    return m;
  endfunction

  function automatic logic [3:0] refCc64(logic [63:0] a, logic [63:0] b);
    logic [63:0] d;
    logic signed [64:0] s;
    d = a - b;
    s = $signed({a[63], a}) - $signed({b[63], b});
    return {d[63], d == 64'h0, s[64] != s[63], a < b};
  endfunction

  function automatic logic [3:0] refCc32(logic [63:0] a, logic [63:0] b);
    logic [31:0] d;
    logic signed [32:0] s;
    d = a[31:0] - b[31:0];
    s = $signed({a[31], a[31:0]}) - $signed({b[31], b[31:0]});
    return {d[31], d == 32'h0, s[32] != s[31], a[31:0] < b[31:0]};
  endfunction

  // driver: drive one request at a falling edge and queue its expectation
  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic le, input logic sf, input logic nw, input string tag);
    item_t it;
    @(negedge clk);
    addrA = a; addrB = b; elemSize = sz; littleEnd = le; setFlags = sf; narrowAddr = nw;
    reqValid = 1'b1;
    if (sf) begin
      curF32 = refCc32(a, b);
      curF64 = refCc64(a, b);
    end
    it.expMask = refMask(a, b, sz, le, nw);
    it.expFv = sf;
    it.expF32 = curF32;
    it.expF64 = curF64;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected result", 64'(resValid), 64'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(mask === it.expMask, {it.tag, " mask"}, mask, it.expMask);
        chk(flagsValid === it.expFv, "R9 flagsValid", 64'(flagsValid), 64'(it.expFv));
        chk(flags32 === it.expF32, {"R8/R9 flags32 ", it.tag}, 64'(flags32), 64'(it.expF32));
        chk(flags64 === it.expF64, {"R8/R9 flags64 ", it.tag}, 64'(flags64), 64'(it.expF64));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(resValid == 1'b0 && flagsValid == 1'b0, "R1 reset valids", {resValid, flagsValid}, 64'h0);
    chk(mask == 64'h0, "R1 reset mask", mask, 64'h0);
    chk(flags32 == 4'h0 && flags64 == 4'h0, "R1 reset flags", {flags32, flags64}, 64'h0);
    rst_n = 1'b1;
    idle(2);
    chk(resValid == 1'b0, "R1 idle no result", 64'(resValid), 64'h0);

    // R2, R6 big-endian bytes: same block -> 1C, other block -> 1F
    issue(64'h1003, 64'h1005, 2'd0, 1'b0, 1'b0, 1'b0, "R2 R6 same blk");
    issue(64'h1003, 64'h2005, 2'd0, 1'b0, 1'b0, 1'b0, "R2 R6 diff blk");
    issue(64'h1000, 64'h1000, 2'd0, 1'b0, 1'b0, 1'b0, "R2 offset0");
    issue(64'h1007, 64'h1007, 2'd0, 1'b0, 1'b0, 1'b0, "R2 offset7");
    // R3 little-endian bytes
    issue(64'h1003, 64'h1005, 2'd0, 1'b1, 1'b0, 1'b0, "R3 same blk");
    issue(64'h1006, 64'h1800, 2'd0, 1'b1, 1'b0, 1'b0, "R3 diff blk");
    // R4 halves
    issue(64'h2002, 64'h2006, 2'd1, 1'b0, 1'b0, 1'b0, "R4 be");
    issue(64'h2004, 64'h2004, 2'd1, 1'b1, 1'b0, 1'b0, "R4 le");
    issue(64'h2003, 64'h3000, 2'd1, 1'b1, 1'b0, 1'b0, "R4 le diff");
    // R5 words and the alternate byte code
    issue(64'h0, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, "R5 be");
    issue(64'h0, 64'h0, 2'd2, 1'b1, 1'b0, 1'b0, "R5 le");
    issue(64'h4, 64'h8, 2'd2, 1'b1, 1'b0, 1'b0, "R5 le diff");
    issue(64'h1003, 64'h1005, 2'd3, 1'b0, 1'b0, 1'b0, "R5 code3 bytes");
    idle(2);
    chk(resValid == 1'b0 && sb.size() == 0, "R1 drained", 64'(sb.size()), 64'h0);

    // R7 narrow addressing: upper halves differ, mask sees same block
    issue(64'hFFFF_FFFF_0000_1000, 64'h0000_0000_0000_1002, 2'd0, 1'b0, 1'b0, 1'b1, "R7 narrow");
    issue(64'hFFFF_FFFF_0000_1000, 64'h0000_0000_0000_1002, 2'd0, 1'b0, 1'b0, 1'b0, "R7 wide");
    // R8 flags incl. borrow, overflow, zero and untruncated use in narrow mode
    issue(64'h5, 64'h7, 2'd0, 1'b0, 1'b1, 1'b0, "R8 borrow");
    issue(64'h8000_0000, 64'h1, 2'd0, 1'b0, 1'b1, 1'b0, "R8 ovf32");
    issue(64'h1_0000_0000, 64'h0, 2'd0, 1'b0, 1'b1, 1'b1, "R8 narrow untrunc");
    issue(64'h8000_0000_0000_0000, 64'h1, 2'd1, 1'b1, 1'b1, 1'b0, "R8 ovf64");
    // R9 flag hold on back-to-back no-flag requests with new addresses
    issue(64'h3, 64'h3, 2'd0, 1'b0, 1'b1, 1'b0, "R9 set zero");
    issue(64'h9, 64'h2, 2'd0, 1'b1, 1'b0, 1'b0, "R9 hold a");
    issue(64'hFFFF_0000, 64'h1, 2'd2, 1'b0, 1'b0, 1'b1, "R9 hold b");
    idle(2);
    chk(flagsValid == 1'b0, "R9 flagsValid idle", 64'(flagsValid), 64'h0);

    // mixed stream, R10 upper bits covered by full-width mask compare
    for (int i = 0; i < 60; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 2 == 0) ? {ra[63:3], 3'($urandom)} : {$urandom, $urandom};
      issue(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R10 mixed");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    chk(sb.size() == 0, "R1 all results seen", 64'(sb.size()), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule